// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation after the translation lookaside buffer has missed. A requester hands it the segment identifier and abbreviated page index of the access, whether the access is an instruction fetch or a data access, whether it is a write, whether the full protection check flagged a violation, and the base addresses of the primary and secondary page table entry groups. Both base addresses are computed elsewhere. The block then reads table entries one by one over a single memory port with one request outstanding at a time, and compares each entry with the access.

On the first matching entry the walk stops. The entry is handed to the TLB with its referenced and changed bits already brought up to date. If either bit had to change, the entry is also written back to the same memory location. If all sixteen entries fail, the block finishes with a storage fault of the class given by the access type. Every accepted request ends in exactly one completion pulse.

Top module: `hpt_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high. `busy` is high from the next cycle up to and including the completion cycle. A request presented while busy is not taken and does not disturb the walk in flight.
- R2: Entry n of a group is read at the group base plus 8·n. The primary group is read from n = 0 to n = 7, and only after all eight fail is the secondary group read in the same order.
- R3: An entry is 64 bits on `mem_rsp_rdata`. Bit 63 is valid, bits 62:39 the segment identifier, bit 38 the hash-select bit, bits 37:32 the abbreviated page index, bits 31:12 the real page number, bit 8 referenced, bit 7 changed, bits 6:3 the storage attributes and bits 1:0 the page protection. A primary entry matches only when valid is 1, hash-select is 0, and both the identifier and the index equal the request.
- R4: A secondary entry matches under the same rule, except that hash-select must be 1.
- R5: On a match no further entry is read. `tlb_wr_en` pulses once with the matched entry, its referenced bit set, and its changed bit as updated by R7.
- R6: After a hit the referenced bit is set, including when `req_prot_viol` is high.
- R7: After a hit the changed bit is set only when `req_is_write` is 1 and `req_prot_viol` is 0. Otherwise it keeps its stored value.
- R8: When R6 and R7 change neither bit, no write is issued. Otherwise one write (`mem_req_we` = 1) of the updated entry goes to the matched entry's address before completion.
- R9: When none of the sixteen entries matches, completion carries `done_isi` for an instruction fetch (`req_is_instr` = 1) or `done_dsi` for a data access. No TLB write and no memory write take place.
- R10: Every entry read carries `mem_req_attr` = 3'b001.
- R11: Each accepted request produces exactly one single-cycle `done` pulse, with exactly one of `done_hit`, `done_isi`, `done_dsi` high.
- R12: A memory request held off by low `mem_req_ready` stays valid with unchanged address and direction until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Block can take a request |
| req_vsid | input | 24 | Segment identifier of the access |
| req_api | input | 6 | Abbreviated page index of the access |
| req_is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_is_write | input | 1 | Access is a store |
| req_prot_viol | input | 1 | Protection check failed for the access |
| req_pri_base | input | 32 | Primary group base address |
| req_sec_base | input | 32 | Secondary group base address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Completion pulse |
| done_hit | output | 1 | Walk found an entry |
| done_isi | output | 1 | Instruction storage fault |
| done_dsi | output | 1 | Data storage fault |
| tlb_wr_en | output | 1 | TLB fill strobe |
| tlb_wr_pte | output | 64 | Entry to fill, with updated R/C |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry written back |
| mem_req_attr | output | 3 | Memory attribute code |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_rdata | input | 64 | Entry read data |

## Verification
The completion pulse of one walk can coincide with a new miss request already waiting at the input. The bench provokes this by keeping `req_valid` high from the first walk onward, with different request fields, while the memory port stalls on alternate cycles. It counts acceptances to judge that the second request is taken only in the cycle after `done`. The first walk's result must reflect its own fields, and the second walk must then find its own entry.

// File: rtl/hpt_pkg.sv
// Shared types for the hashed page table walker.
// Assumes a fixed 64-bit entry layout; only the group geometry is parametric.
package hpt_pkg;

    localparam int VSID_W      = 24;
    localparam int API_W       = 6;
    localparam int TAG_W       = 1 + VSID_W + 1 + API_W;
    localparam int ENTRY_W     = 64;
    localparam int ENTRY_BYTES = 8;
    localparam logic [2:0] READ_ATTR = 3'b001;

    // Entry layout, most significant field first.
    typedef struct packed {
        logic               v;
        logic [VSID_W-1:0]  vsid;
        logic               h;
        logic [API_W-1:0]   api;
        logic [19:0]        rpn;
        logic [2:0]         rsv0;
        logic               r;
        logic               c;
        logic [3:0]         wimg;
        logic               rsv1;
        logic [1:0]         pp;
    } pte_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_REQ,
        W_RD_WAIT,
        W_FILL,
        W_WB_REQ,
        W_WB_WAIT,
        W_DONE
    } walk_state_t;

endpackage

// File: rtl/hpt_pte_match.sv
// Compares the tag word of one entry with the access.
// Assumes the tag word holds valid, identifier, hash-select and page index,
// in that order from the top bit down.
module hpt_pte_match
    import hpt_pkg::*;
(
    input  logic [TAG_W-1:0]  tag_word,
    input  logic [VSID_W-1:0] vsid,
    input  logic [API_W-1:0]  api,
    input  logic              want_h,
    output logic              hit
);

    logic [TAG_W-1:0] expect_tag;

    // Build the tag a matching entry must carry and compare it whole.
    always_comb begin
        expect_tag = {1'b1, vsid, want_h, api};
        hit        = (tag_word == expect_tag);
    end

endmodule

// File: rtl/hpt_rc_update.sv
// Computes the referenced/changed update for a matched entry.
// Assumes the caller applies the result only on a hit.
module hpt_rc_update
    import hpt_pkg::*;
(
    input  pte_t pte_in,
    input  logic is_write,
    input  logic prot_viol,
    output pte_t pte_out,
    output logic need_wb
);

    logic set_c;

    // Referenced is always set; changed only for a permitted store.
    always_comb begin
        set_c     = is_write && !prot_viol;
        pte_out   = pte_in;
        pte_out.r = 1'b1;
        if (set_c) begin
            pte_out.c = 1'b1;
        end
        need_wb   = !pte_in.r || (set_c && !pte_in.c);
    end

endmodule

// File: rtl/hpt_walker.sv
// Two-pass hashed page table walker.
// Reads up to GROUP_ENTRIES entries of the primary group, then of the
// secondary group, one read outstanding at a time. On a hit, fills the TLB
// and writes back R/C if they changed. On a full miss, raises a storage fault.
// Assumes group bases are computed by the requester and are entry-aligned,
// and that the memory answers every accepted request with one response.
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int GROUP_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_vsid,
    input  logic [5:0]        req_api,
    input  logic              req_is_instr,
    input  logic              req_is_write,
    input  logic              req_prot_viol,
    input  logic [ADDR_W-1:0] req_pri_base,
    input  logic [ADDR_W-1:0] req_sec_base,
    output logic              busy,
    output logic              done,
    output logic              done_hit,
    output logic              done_isi,
    output logic              done_dsi,
    output logic              tlb_wr_en,
    output logic [63:0]       tlb_wr_pte,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [63:0]       mem_req_wdata,
    output logic [2:0]        mem_req_attr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_rdata
);

    localparam int IDX_W  = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
    localparam int OFF_SH = $clog2(ENTRY_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

    walk_state_t       state_q, state_d;
    logic              second_q;
    logic [IDX_W-1:0]  idx_q;
    logic [VSID_W-1:0] vsid_q;
    logic [API_W-1:0]  api_q;
    logic              instr_q, write_q, viol_q;
    logic [ADDR_W-1:0] pri_q, sec_q;
    pte_t              pte_q;
    logic              wb_need_q;
    logic              hit_q;

    logic              accept;
    logic              rsp_match;
    pte_t              rsp_pte;
    pte_t              upd_pte;
    logic              upd_need;
    logic [ADDR_W-1:0] entry_addr;

    assign rsp_pte = pte_t'(mem_rsp_rdata);

    hpt_pte_match u_match (
        .tag_word (mem_rsp_rdata[ENTRY_W-1 -: TAG_W]),
        .vsid     (vsid_q),
        .api      (api_q),
        .want_h   (second_q),
        .hit      (rsp_match)
    );

    hpt_rc_update u_rc (
        .pte_in    (rsp_pte),
        .is_write  (write_q),
        .prot_viol (viol_q),
        .pte_out   (upd_pte),
        .need_wb   (upd_need)
    );

    // Address of the entry under examination in the current group.
    always_comb begin
        entry_addr = (second_q ? sec_q : pri_q)
                   + (ADDR_W'(idx_q) << OFF_SH);
    end

    // Handshake and status outputs decoded from the walk state.
    always_comb begin
        req_ready = (state_q == W_IDLE);
        accept    = req_valid && req_ready;
        busy      = (state_q != W_IDLE);
        done      = (state_q == W_DONE);
        done_hit  = done && hit_q;
        done_isi  = done && !hit_q && instr_q;
        done_dsi  = done && !hit_q && !instr_q;
        tlb_wr_en = (state_q == W_FILL);
        tlb_wr_pte = pte_q;
    end

    // Memory request drive: reads during search, one write for R/C.
    always_comb begin
        mem_req_valid = (state_q == W_RD_REQ) || (state_q == W_WB_REQ);
        mem_req_we    = (state_q == W_WB_REQ);
        mem_req_addr  = entry_addr;
        mem_req_wdata = pte_q;
        mem_req_attr  = (state_q == W_RD_REQ) ? READ_ATTR : 3'b000;
    end

    // Next-state logic for the walk.
    always_comb begin
        state_d = state_q;
        case (state_q)
            W_IDLE: begin
                if (accept) begin
                    state_d = W_RD_REQ;
                end
            end
            W_RD_REQ: begin
                if (mem_req_ready) begin
                    state_d = W_RD_WAIT;
                end
            end
            W_RD_WAIT: begin
                if (mem_rsp_valid) begin
                    if (rsp_match) begin
                        state_d = W_FILL;
                    end else if (idx_q == LAST_IDX && second_q) begin
                        state_d = W_DONE;
                    end else begin
                        state_d = W_RD_REQ;
                    end
                end
            end
            W_FILL: begin
                state_d = wb_need_q ? W_WB_REQ : W_DONE;
            end
            W_WB_REQ: begin
                if (mem_req_ready) begin
                    state_d = W_WB_WAIT;
                end
            end
            W_WB_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = W_DONE;
                end
            end
            W_DONE: begin
                state_d = W_IDLE;
            end
            default: begin
                state_d = W_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsid_q  <= '0;
            api_q   <= '0;
            instr_q <= 1'b0;
            write_q <= 1'b0;
            viol_q  <= 1'b0;
            pri_q   <= '0;
            sec_q   <= '0;
        end else if (accept) begin
            vsid_q  <= req_vsid;
            api_q   <= req_api;
            instr_q <= req_is_instr;
            write_q <= req_is_write;
            viol_q  <= req_prot_viol;
            pri_q   <= req_pri_base;
            sec_q   <= req_sec_base;
        end
    end

    // Entry position: index within group and which group is searched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            second_q <= 1'b0;
        end else if (accept) begin
            idx_q    <= '0;
            second_q <= 1'b0;
        end else if (state_q == W_RD_WAIT && mem_rsp_valid && !rsp_match) begin
            if (idx_q == LAST_IDX) begin
                if (!second_q) begin
                    idx_q    <= '0;
                    second_q <= 1'b1;
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Hit capture: updated entry, write-back need and outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_q     <= '0;
            wb_need_q <= 1'b0;
            hit_q     <= 1'b0;
        end else if (accept) begin
            wb_need_q <= 1'b0;
            hit_q     <= 1'b0;
        end else if (state_q == W_RD_WAIT && mem_rsp_valid && rsp_match) begin
            pte_q     <= upd_pte;
            wb_need_q <= upd_need;
            hit_q     <= 1'b1;
        end
    end

endmodule

// File: rtl/hpt_walker_chk.sv
// Property checker for the page table walker, attached by bind.
// Observes only top-level ports.
module hpt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              done_hit,
    input logic              done_isi,
    input logic              done_dsi,
    input logic              tlb_wr_en,
    input logic [63:0]       tlb_wr_pte,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [63:0]       mem_req_wdata,
    input logic [2:0]        mem_req_attr
);

    // R10
    read_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_we) |-> (mem_req_attr == 3'b001));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({done_hit, done_isi, done_dsi}) == 1));

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

    // R5
    tlb_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |-> (busy && tlb_wr_pte[63] && tlb_wr_pte[8]));

    // R8
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata[8] && mem_req_wdata[63]));

endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .busy          (busy),
    .done          (done),
    .done_hit      (done_hit),
    .done_isi      (done_isi),
    .done_dsi      (done_dsi),
    .tlb_wr_en     (tlb_wr_en),
    .tlb_wr_pte    (tlb_wr_pte),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_req_attr  (mem_req_attr)
);

// File: tb/hpt_walker_tb.sv
// Directed bench for the page table walker: one task per scenario.
module hpt_walker_tb;

    localparam logic [31:0] PRI = 32'h0000_1000;
    localparam logic [31:0] SEC = 32'h0000_2400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vsid = '0;
    logic [5:0]  req_api = '0;
    logic        req_is_instr = 1'b0;
    logic        req_is_write = 1'b0;
    logic        req_prot_viol = 1'b0;
    logic [31:0] req_pri_base = PRI;
    logic [31:0] req_sec_base = SEC;
    logic        busy, done, done_hit, done_isi, done_dsi;
    logic        tlb_wr_en;
    logic [63:0] tlb_wr_pte;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic [2:0]  mem_req_attr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic stall = 1'b0;

    logic [63:0] tbl [32];
    int rd_cnt = 0, wb_cnt = 0, tlb_cnt = 0, acc_cnt = 0;
    int order_err = 0, attr_err = 0, walk_rd = 0;
    logic [31:0] w_pri = '0, w_sec = '0;
    logic [63:0] last_tlb = '0, last_wb = '0;
    logic [31:0] last_wb_addr = '0;

    always #10 clk = ~clk;

    assign mem_req_ready = stall ? cyc[0] : 1'b1;

    hpt_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vsid(req_vsid), .req_api(req_api),
        .req_is_instr(req_is_instr), .req_is_write(req_is_write),
        .req_prot_viol(req_prot_viol),
        .req_pri_base(req_pri_base), .req_sec_base(req_sec_base),
        .busy(busy), .done(done), .done_hit(done_hit),
        .done_isi(done_isi), .done_dsi(done_dsi),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_pte(tlb_wr_pte),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_attr(mem_req_attr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [63:0] mk(input logic v, input logic [23:0] vs,
                                       input logic h, input logic [5:0] ap,
                                       input logic [19:0] rpn,
                                       input logic r, input logic c);
        return {v, vs, h, ap, rpn, 3'b000, r, c, 4'b0010, 1'b0, 2'b10};
    endfunction

    function automatic int slot(input logic [31:0] a);
        if (a >= SEC) return 16 + int'((a - SEC) >> 3);
        return int'((a - PRI) >> 3);
    endfunction

    // Memory model and port monitor.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (req_valid && req_ready) begin
            acc_cnt <= acc_cnt + 1;
            walk_rd <= 0;
            w_pri   <= req_pri_base;
            w_sec   <= req_sec_base;
        end
        if (tlb_wr_en) begin
            tlb_cnt  <= tlb_cnt + 1;
            last_tlb <= tlb_wr_pte;
        end
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            if (mem_req_we) begin
                wb_cnt       <= wb_cnt + 1;
                last_wb      <= mem_req_wdata;
                last_wb_addr <= mem_req_addr;
                tbl[slot(mem_req_addr)] <= mem_req_wdata;
            end else begin
                rd_cnt  <= rd_cnt + 1;
                walk_rd <= walk_rd + 1;
                if (mem_req_attr != 3'b001) attr_err <= attr_err + 1;
                if (mem_req_addr != ((walk_rd < 8) ? w_pri + 32'(walk_rd * 8)
                                                   : w_sec + 32'((walk_rd - 8) * 8)))
                    order_err <= order_err + 1;
                mem_rsp_rdata <= tbl[slot(mem_req_addr)];
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung (actual cyc=%0d expected <150000)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_tbl();
        for (int i = 0; i < 32; i++) tbl[i] = '0;
    endtask

    // Drive one request and wait for completion; outcome in o_*.
    logic o_hit, o_isi, o_dsi;
    int   b_rd, b_wb, b_tlb, b_ord, b_attr;

    task automatic walk(input logic [23:0] vs, input logic [5:0] ap,
                        input logic instr, input logic wr, input logic viol);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        b_rd = rd_cnt; b_wb = wb_cnt; b_tlb = tlb_cnt;
        b_ord = order_err; b_attr = attr_err;
        req_vsid = vs; req_api = ap; req_is_instr = instr;
        req_is_write = wr; req_prot_viol = viol; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        o_hit = done_hit; o_isi = done_isi; o_dsi = done_dsi;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R11 done after reset", 64'(done), 64'd0);
        chk("R12 mem idle after reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_primary_hit();
        logic [63:0] e;
        clear_tbl();
        e = mk(1'b1, 24'h123456, 1'b0, 6'h15, 20'h0A003, 1'b0, 1'b0);
        tbl[3] = e;
        walk(24'h123456, 6'h15, 1'b0, 1'b0, 1'b0);
        chk("R3 primary hit", 64'(o_hit), 64'd1);
        chk("R5 stop after entry 3", 64'(rd_cnt - b_rd), 64'd4);
        chk("R2 read order", 64'(order_err - b_ord), 64'd0);
        chk("R5 tlb entry", last_tlb, mk(1'b1, 24'h123456, 1'b0, 6'h15, 20'h0A003, 1'b1, 1'b0));
        chk("R5 one tlb write", 64'(tlb_cnt - b_tlb), 64'd1);
        chk("R6 R write-back", last_wb, mk(1'b1, 24'h123456, 1'b0, 6'h15, 20'h0A003, 1'b1, 1'b0));
        chk("R8 write-back address", 64'(last_wb_addr), 64'(PRI + 32'd24));
        chk("R10 read attribute", 64'(attr_err - b_attr), 64'd0);
    endtask

    task automatic t_secondary_hit();
        logic [63:0] e;
        clear_tbl();
        tbl[1] = mk(1'b1, 24'hABCDEF, 1'b1, 6'h2A, 20'h00001, 1'b0, 1'b0);
        tbl[4] = mk(1'b1, 24'hABCDEF, 1'b0, 6'h2B, 20'h00004, 1'b0, 1'b0);
        tbl[6] = mk(1'b0, 24'hABCDEF, 1'b0, 6'h2A, 20'h00006, 1'b0, 1'b0);
        tbl[18] = mk(1'b1, 24'hABCDEE, 1'b1, 6'h2A, 20'h00012, 1'b0, 1'b0);
        e = mk(1'b1, 24'hABCDEF, 1'b1, 6'h2A, 20'h0B005, 1'b1, 1'b0);
        tbl[21] = e;
        walk(24'hABCDEF, 6'h2A, 1'b0, 1'b0, 1'b0);
        chk("R4 secondary hit", 64'(o_hit), 64'd1);
        chk("R3 primary decoys skipped, reads", 64'(rd_cnt - b_rd), 64'd14);
        chk("R2 two-pass order", 64'(order_err - b_ord), 64'd0);
        chk("R4 tlb entry", last_tlb, e);
        chk("R8 no write-back when R already set", 64'(wb_cnt - b_wb), 64'd0);
        chk("R8 memory copy unchanged", tbl[21], e);
    endtask

    task automatic t_fault(input logic instr);
        clear_tbl();
        for (int i = 0; i < 8; i++) begin
            tbl[i] = mk(1'b1, 24'h000777, 1'b1, 6'h01, 20'(i), 1'b0, 1'b0);
            tbl[16 + i] = mk(1'b1, 24'h000777, 1'b0, 6'h01, 20'(i), 1'b0, 1'b0);
        end
        walk(24'h000777, 6'h01, instr, 1'b0, 1'b0);
        chk("R9 all sixteen read", 64'(rd_cnt - b_rd), 64'd16);
        chk("R9 fault class", 64'({o_hit, o_isi, o_dsi}), instr ? 64'b010 : 64'b001);
        chk("R9 no tlb write", 64'(tlb_cnt - b_tlb), 64'd0);
        chk("R9 no memory write", 64'(wb_cnt - b_wb), 64'd0);
    endtask

    task automatic t_rc(input string tag, input logic second, input int pos,
                        input logic wr, input logic viol, input logic r0, input logic c0,
                        input logic exp_wb, input logic r1, input logic c1);
        clear_tbl();
        tbl[(second ? 16 : 0) + pos] = mk(1'b1, 24'h5A5A5A, second, 6'h33, 20'hC0DE0, r0, c0);
        walk(24'h5A5A5A, 6'h33, 1'b0, wr, viol);
        chk({tag, " hit"}, 64'(o_hit), 64'd1);
        chk({tag, " tlb R/C"}, 64'({last_tlb[8], last_tlb[7]}), 64'({r1, c1}));
        chk({tag, " write-back count"}, 64'(wb_cnt - b_wb), 64'(exp_wb));
        chk({tag, " memory R/C"}, 64'({tbl[(second ? 16 : 0) + pos][8], tbl[(second ? 16 : 0) + pos][7]}),
            64'({r1, c1}));
    endtask

    task automatic t_holdoff();
        int a0;
        clear_tbl();
        tbl[2] = mk(1'b1, 24'h111111, 1'b0, 6'h05, 20'h11111, 1'b1, 1'b0);
        tbl[16 + 1] = mk(1'b1, 24'h222222, 1'b1, 6'h06, 20'h22222, 1'b1, 1'b0);
        stall = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        a0 = acc_cnt;
        b_rd = rd_cnt; b_ord = order_err;
        req_vsid = 24'h111111; req_api = 6'h05; req_is_instr = 1'b0;
        req_is_write = 1'b0; req_prot_viol = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_vsid = 24'h222222; req_api = 6'h06;
        while (!done) @(negedge clk);
        chk("R1 first walk result", 64'(done_hit), 64'd1);
        chk("R1 first walk own entry", 64'(last_tlb[31:12]), 64'h11111);
        chk("R1 no accept while busy", 64'(acc_cnt - a0), 64'd1);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 second accepted after done", 64'(acc_cnt - a0), 64'd2);
        while (!done) @(negedge clk);
        chk("R1 second walk hit", 64'(done_hit), 64'd1);
        chk("R12 second walk own entry", 64'(last_tlb[31:12]), 64'h22222);
        chk("R12 order under stall", 64'(order_err - b_ord), 64'd0);
        stall = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_primary_hit();
        t_secondary_hit();
        t_fault(1'b0);
        t_fault(1'b1);
        t_rc("R7 store sets C", 1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        t_rc("R6 violation sets R only", 1'b0, 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        t_rc("R8 store with R/C set skips", 1'b0, 5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        t_rc("R7 store sets C alone", 1'b1, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        t_rc("R7 load keeps C clear", 1'b0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        t_holdoff();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule